// File: doc/BRIEF.md
# Distributed-Arithmetic Complex Constant Multiplier

This block multiplies a streamed complex operand X = a + jb by a complex constant K = c + jd that is fixed when the block is built. Both operand parts are two's-complement words of WD bits. They arrive one bit per clock, least significant bit first, on two serial inputs. The block does not use real multipliers. It stores only the two sums c+d and c-d. On each bit a small crossbar routes one of them to the real path and the other to the imaginary path, and each path adds or subtracts its value in a shift-accumulator. The choice of route depends on whether the two data bits differ. The sign of each update depends on the data bit, and it is inverted in the sign-bit cycle.

The constant offset term of the offset-binary expansion is preloaded into each accumulator in the first cycle, so a product costs exactly WD cycles. After the last bit, re_o = c·a − d·b and im_o = d·a + c·b appear as exact integers, with a one-cycle done_o pulse. A new operand may start in the cycle straight after the last bit of the previous one.

Top module: `dac_cmul`

## Requirements
- R1: After a run, re_o equals the exact integer c·a − d·b, where a and b are the WD-bit two's-complement operands and c, d are the WC-bit signed constants.
- R2: After a run, im_o equals the exact integer d·a + c·b.
- R3: A run is accepted when start_i is high while the block is idle. done_o goes high for exactly one cycle, in the cycle that follows the clock edge sampling the last operand bit, which is WD edges after acceptance.
- R4: A start_i pulse during a run is ignored. The run's timing and results are unchanged.
- R5: A new run can be accepted in the cycle directly after the last bit of the previous run, with no idle cycle between them, and both results are exact.
- R6: re_o and im_o keep their values in every cycle in which done_o is low.
- R7: Extreme operands, including the most negative value on both parts, give exact results with no overflow. The result width is WC+WD+1 bits.
- R8: While rst_ni is low, and after it is released with no run, done_o, re_o and im_o are zero.
- R9: Bit k of a and of b (k = 0 is the LSB) is presented on a_bit_i and b_bit_i in the k-th cycle of a run. Cycle 0 is the start_i cycle, and the sign bit comes in cycle WD−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Marks bit 0 of a new operand pair |
| a_bit_i | input | 1 | Serial real operand bit, LSB first |
| b_bit_i | input | 1 | Serial imaginary operand bit, LSB first |
| re_o | output | WC+WD+1 | Real part of the product, signed |
| im_o | output | WC+WD+1 | Imaginary part of the product, signed |
| done_o | output | 1 | One-cycle pulse when re_o and im_o are updated |

## Verification
The product of an accepted run is due WD clock edges after the edge that accepts start_i. It appears in the cycle after the sign bit is sampled. The bench keeps a behavioural model that counts edges from acceptance. That model predicts done_o and the exact products for every cycle. The outputs are compared against it at each falling edge, away from the edge where they change. In every other cycle the bench requires the previous result to hold. This covers runs that are back to back, stray start pulses in the middle of a run, and the extreme operand values.

// File: rtl/dac_pkg.sv
package dac_pkg;
  typedef enum logic {PATH_RE = 1'b0, PATH_IM = 1'b1} path_e;

  // sign-bit cycle inverts the add/subtract sense
  function automatic logic sub_sel(input logic data_bit, input logic sign_cyc);
    return sign_cyc ? data_bit : ~data_bit;
  endfunction
endpackage

// File: rtl/dac_ctrl.sv
module dac_ctrl #(
  parameter int WD = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic first_o,
  output logic sign_o,
  output logic busy_o
);
  localparam int CNT_W = (WD > 2) ? $clog2(WD) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WD - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] bit_idx;

  assign first_o  = start_i & ~busy_q;
  assign active_o = busy_q | start_i;
  assign bit_idx  = busy_q ? cnt_q : '0;
  assign sign_o   = active_o & (bit_idx == LAST_IDX);
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (first_o) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(1);
    end else if (busy_q) begin
      if (cnt_q == LAST_IDX) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/dac_route.sv
module dac_route #(
  parameter int WC = 8,
  parameter int CW = WC + 2,
  parameter logic signed [WC-1:0] C_K = 8'sd90,
  parameter logic signed [WC-1:0] D_K = -8'sd37
) (
  input  logic                 a_bit_i,
  input  logic                 b_bit_i,
  input  logic                 sign_i,
  output logic signed [CW-1:0] coef_re_o,
  output logic signed [CW-1:0] coef_im_o,
  output logic                 neg_re_o,
  output logic                 neg_im_o,
  output logic signed [CW-1:0] preset_re_o,
  output logic signed [CW-1:0] preset_im_o
);
  import dac_pkg::*;

  localparam logic signed [CW-1:0] K_SUM = CW'(C_K) + CW'(D_K);
  localparam logic signed [CW-1:0] K_DIF = CW'(C_K) - CW'(D_K);

  logic swap;
  assign swap = a_bit_i ^ b_bit_i;

  // equal bits: re <- c-d, im <- c+d; differing bits: swapped
  assign coef_re_o = swap ? K_SUM : K_DIF;
  assign coef_im_o = swap ? K_DIF : K_SUM;

  assign neg_re_o = sub_sel(a_bit_i, sign_i);
  assign neg_im_o = sub_sel(b_bit_i, sign_i);

  // all-zero address value, folded into the first accumulation
  assign preset_re_o = -K_DIF;
  assign preset_im_o = -K_SUM;
endmodule

// File: rtl/dac_shift_acc.sv
module dac_shift_acc #(
  parameter int WC = 8,
  parameter int WD = 8,
  parameter int CW = WC + 2,
  parameter int AW = WC + 2,
  parameter int RES_W = WC + WD + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    first_i,
  input  logic                    last_i,
  input  logic                    neg_i,
  input  logic signed [CW-1:0]    coef_i,
  input  logic signed [CW-1:0]    preset_i,
  output logic signed [RES_W-1:0] res_o
);
  localparam int HI_W = RES_W - (WD - 1);

  logic signed [AW-1:0]    acc_q;
  logic        [WD-1:0]    low_q;
  logic signed [RES_W-1:0] res_q;

  logic signed [AW:0] base_x;
  logic        [AW:0] opnd_x;
  logic        [AW:0] sum_x;
  logic signed [AW-1:0] acc_nx;
  logic        [WD-1:0] low_nx;

  assign base_x = first_i ? (AW+1)'(preset_i) : (AW+1)'(acc_q);
  // subtract: invert operand and inject a carry at the LSB
  assign opnd_x = (AW+1)'(coef_i) ^ {(AW+1){neg_i}};
  assign sum_x  = base_x + opnd_x + (AW+1)'(neg_i);
  assign acc_nx = sum_x[AW:1];
  assign low_nx = {sum_x[0], low_q[WD-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      low_q <= '0;
      res_q <= '0;
    end else if (en_i) begin
      acc_q <= acc_nx;
      low_q <= low_nx;
      if (last_i) res_q <= {acc_nx[HI_W-1:0], low_nx[WD-1:1]};
    end
  end

  assign res_o = res_q;
endmodule

// File: rtl/dac_cmul.sv
module dac_cmul #(
  parameter int WD = 8,
  parameter int WC = 8,
  parameter logic signed [WC-1:0] C_K = 8'sd90,
  parameter logic signed [WC-1:0] D_K = -8'sd37,
  localparam int RES_W = WC + WD + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    a_bit_i,
  input  logic                    b_bit_i,
  output logic signed [RES_W-1:0] re_o,
  output logic signed [RES_W-1:0] im_o,
  output logic                    done_o
);
  import dac_pkg::*;

  localparam int CW = WC + 2;
  localparam int AW = WC + 2;

  logic active, first, sign_cyc, busy, done_q;
  logic signed [CW-1:0] coef [2];
  logic signed [CW-1:0] preset [2];
  logic                 neg [2];
  logic signed [RES_W-1:0] res [2];

  dac_ctrl #(.WD(WD)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .active_o(active), .first_o(first), .sign_o(sign_cyc), .busy_o(busy)
  );

  dac_route #(.WC(WC), .CW(CW), .C_K(C_K), .D_K(D_K)) u_route (
    .a_bit_i, .b_bit_i, .sign_i(sign_cyc),
    .coef_re_o(coef[PATH_RE]), .coef_im_o(coef[PATH_IM]),
    .neg_re_o(neg[PATH_RE]), .neg_im_o(neg[PATH_IM]),
    .preset_re_o(preset[PATH_RE]), .preset_im_o(preset[PATH_IM])
  );

  for (genvar p = 0; p < 2; p++) begin : g_path
    dac_shift_acc #(.WC(WC), .WD(WD), .CW(CW), .AW(AW), .RES_W(RES_W)) u_acc (
      .clk_i, .rst_ni,
      .en_i(active), .first_i(first), .last_i(sign_cyc),
      .neg_i(neg[p]), .coef_i(coef[p]), .preset_i(preset[p]),
      .res_o(res[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= sign_cyc;
  end

  assign re_o   = res[PATH_RE];
  assign im_o   = res[PATH_IM];
  assign done_o = done_q;
endmodule

// File: rtl/dac_cmul_chk.sv
module dac_cmul_chk #(
  parameter int WD = 8,
  parameter int RES_W = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_i,
  input logic             done_i,
  input logic [RES_W-1:0] re_i,
  input logic [RES_W-1:0] im_i
);
  logic        accept;
  logic [1:0]  inflight_q;
  logic [31:0] run_len_q;

  assign accept = start_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inflight_q <= '0;
      run_len_q  <= '0;
    end else begin
      inflight_q <= inflight_q + 2'(accept) - 2'(done_i);
      if (accept) run_len_q <= 32'd1;
      else if (run_len_q != 0 && run_len_q < WD) run_len_q <= run_len_q + 32'd1;
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_done_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> run_len_q == WD);

  p_one_in_flight_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= 2'd1);

  p_done_has_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> inflight_q == 2'd1);

  p_hold_result_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> ($stable(re_i) && $stable(im_i)));
endmodule

bind dac_cmul dac_cmul_chk #(.WD(WD), .RES_W(RES_W)) u_chk (
  .clk_i, .rst_ni, .start_i, .busy_i(busy), .done_i(done_o), .re_i(re_o), .im_i(im_o)
);

// File: tb/dac_cmul_test.sv
module dac_cmul_test;
  localparam int WD = 8;
  localparam int WC = 8;
  localparam int C_V = 90;
  localparam int D_V = -37;
  localparam int RES_W = WC + WD + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, a_bit = 1'b0, b_bit = 1'b0;
  logic signed [RES_W-1:0] re, im;
  logic done;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dac_cmul #(.WD(WD), .WC(WC), .C_K(WC'(C_V)), .D_K(WC'(D_V))) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_bit_i(a_bit), .b_bit_i(b_bit),
    .re_o(re), .im_o(im), .done_o(done)
  );

  // driver-side operand of the run being started, with its requirement tag
  int cur_a = 0, cur_b = 0;
  string cur_tag = "R9";

  // behavioural reference model, updated on rising edges
  bit m_busy = 0, m_done = 0;
  int m_cnt = 0, m_a = 0, m_b = 0;
  string m_tag = "";
  int exp_re = 0, exp_im = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == WD) begin
          m_busy = 0;
          m_done = 1;
          exp_re = C_V * m_a - D_V * m_b;
          exp_im = D_V * m_a + C_V * m_b;
        end
      end else if (start) begin
        m_busy = 1;
        m_cnt  = 1;
        m_a = cur_a; m_b = cur_b; m_tag = cur_tag;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // per-cycle comparison away from the active edge
  int prev_re = 0, prev_im = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(done == m_done, "R3 done timing", int'(done), int'(m_done));
      if (m_done) begin
        check(int'(re) == exp_re, {"R1 real ", m_tag}, int'(re), exp_re);
        check(int'(im) == exp_im, {"R2 imag ", m_tag}, int'(im), exp_im);
      end else begin
        check(int'(re) == prev_re, "R6 real hold", int'(re), prev_re);
        check(int'(im) == prev_im, "R6 imag hold", int'(im), prev_im);
      end
      prev_re = int'(re);
      prev_im = int'(im);
    end
  end

  task automatic run_op(input int av, input int bv, input bit poke, input string tag);
    for (int k = 0; k < WD; k++) begin
      @(negedge clk);
      if (k == 0) begin cur_a = av; cur_b = bv; cur_tag = tag; end
      start = (k == 0) || (poke && (k == WD / 2 || k == WD - 1));
      a_bit = av[k];
      b_bit = bv[k];
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      start = 1'b0;
      a_bit = 1'($urandom);
      b_bit = 1'($urandom);
    end
  endtask

  function automatic int rnd_op();
    return int'($urandom_range(0, (1 << WD) - 1)) - (1 << (WD - 1));
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int lo, hi;
    lo = -(1 << (WD - 1));
    hi = (1 << (WD - 1)) - 1;
    repeat (3) @(negedge clk);
    // R8: in reset
    check(done == 1'b0 && re == '0 && im == '0, "R8 in reset", int'(re) + int'(im), 0);
    rst_n = 1'b1;
    idle(3);
    check(done == 1'b0 && re == '0 && im == '0, "R8 after release", int'(re) + int'(im), 0);

    // R9 basic patterns
    run_op(1, 0, 0, "R9"); idle(2);
    run_op(0, 1, 0, "R9"); idle(1);
    run_op(0, 0, 0, "R9"); idle(1);
    run_op(-1, -1, 0, "R9"); idle(1);
    // R7 extremes
    run_op(lo, lo, 0, "R7"); idle(1);
    run_op(hi, hi, 0, "R7"); idle(1);
    run_op(lo, hi, 0, "R7"); idle(1);
    run_op(hi, lo, 0, "R7"); idle(2);
    // R4 stray starts during a run
    run_op(37, -90, 1, "R4"); idle(1);
    run_op(lo, 5, 1, "R4"); idle(2);
    // R5 back to back
    run_op(12, -7, 0, "R5");
    run_op(lo, lo, 0, "R5");
    run_op(-100, 77, 1, "R5");
    idle(3);
    // random operands, mixed gaps and stray starts
    for (int i = 0; i < 300; i++) begin
      run_op(rnd_op(), rnd_op(), 1'($urandom_range(0, 3) == 0), "R9");
      if ($urandom_range(0, 1) == 1) idle(int'($urandom_range(1, 3)));
    end
    idle(4);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule